// File: doc/BRIEF.md
# Ternary Match Table with Activity Tracking

This block is a small ternary match table for packet classification. Each entry stores a search key, a per-bit care mask, an action word, a valid flag and a hit-activity flag. On the lookup side a search key is presented with a strobe. One clock later the table reports whether any valid entry matched, the lowest matching entry index, and that entry's action word. The winning entry's activity flag is set by the same lookup.

A management port works on one entry per cycle, chosen by a 16-bit offset. It can read an entry, read it and then clear its activity flag, write the whole entry, replace only its action, or clear only its activity flag. A full write marks the entry active. A full write with the valid flag low deletes the entry. An offset past the table depth has no effect and raises a one-cycle error pulse. Software uses the activity flags to age out unused rules.

Top module: `tmatch_table`

## Requirements
- R1: An entry matches a search key when every key bit whose mask bit is 1 equals the search bit. Key bits whose mask bit is 0 are ignored.
- R2: Only valid entries can match, and the lowest matching index wins.
  - `res_vld` is high in the cycle after the cycle in which `srch_vld` was sampled high.
  - With `res_vld`, `res_hit` reports a match, `res_idx` gives the winning index and `res_act` gives the winner's action.
  - On a miss, `res_hit`, `res_idx` and `res_act` are all zero.
- R3: A lookup that hits sets the activity flag of the winning entry only.
- R4: A query is `mgmt_vld`=1 with `mgmt_wr`=0. Every query code except 1 is a plain read.
  - One cycle later `rd_vld` pulses, and `rd_key`, `rd_mask`, `rd_act`, `rd_valid` and `rd_active` show the entry as it was.
  - The entry is not changed.
- R5: Query code 1 (`mgmt_op`=1) returns the entry as in R4, with its activity flag as it was before the operation. The entry's activity flag is then cleared.
- R6: Write code 0 (`mgmt_wr`=1, `mgmt_op`=0) stores the key, mask, action and valid inputs into the entry and sets its activity flag. `rd_vld` stays low for every write.
- R7: A code 0 write with `mgmt_valid`=0 deletes the entry, and it stops matching lookups.
- R8: Write code 1 replaces only the action word. Key, mask, valid and activity are left unchanged.
- R9: Write code 2 clears only the activity flag. Write code 3 changes nothing.
- R10: A lookup hit on an entry and an activity clear of that same entry can fall in the same cycle, by write code 2 or by query code 1. The hit wins and the flag remains set.
- R11: A management operation whose offset is not below the depth (16) changes no entry and produces no `rd_vld`. `mgmt_err` pulses high in the next cycle.
- R12: After synchronous reset (`rst_n` low at a clock edge) every entry is invalid, inactive and all-zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| srch_vld | input | 1 | Lookup strobe |
| srch_key | input | KEY_W (32) | Lookup key |
| res_vld | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup matched a valid entry |
| res_idx | output | IDX_W (4) | Lowest matching entry index |
| res_act | output | ACT_W (16) | Action of the winning entry |
| mgmt_vld | input | 1 | Management operation strobe |
| mgmt_wr | input | 1 | 1 = write family, 0 = query family |
| mgmt_op | input | 2 | Operation code within the family |
| mgmt_off | input | OFF_W (16) | Entry offset |
| mgmt_key | input | KEY_W (32) | Key for a full write |
| mgmt_mask | input | KEY_W (32) | Care mask for a full write |
| mgmt_act | input | ACT_W (16) | Action for a full write or action update |
| mgmt_valid | input | 1 | Valid flag for a full write |
| rd_vld | output | 1 | Query data valid |
| rd_key | output | KEY_W (32) | Queried key |
| rd_mask | output | KEY_W (32) | Queried mask |
| rd_act | output | ACT_W (16) | Queried action |
| rd_valid | output | 1 | Queried valid flag |
| rd_active | output | 1 | Queried activity flag before any clear |
| mgmt_err | output | 1 | Offset out of range on the last operation |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before use. They also assume that all control inputs are known (never X) outside reset, so the activity and update properties can be read one cycle after their cause.

No input protocol is needed otherwise, because lookups and management operations may coincide on any entry. The stimulus therefore drives both ports in the same cycles on purpose. It draws keys and table keys from a narrow family so that hits, multiple matches and masked bits happen often. About one management offset in sixteen is out of range.

// File: rtl/tmatch_pkg.sv
// Shared operation codes for the ternary match table.
// Assumes the management port carries a family bit plus a 2-bit code.
package tmatch_pkg;
    // Query family (mgmt_wr = 0)
    localparam logic [1:0] QRY_PLAIN     = 2'd0;
    localparam logic [1:0] QRY_CLEAR_ACT = 2'd1;
    // Write family (mgmt_wr = 1)
    localparam logic [1:0] WR_FULL       = 2'd0;
    localparam logic [1:0] WR_ACTION     = 2'd1;
    localparam logic [1:0] WR_CLEAR_ACT  = 2'd2;
endpackage

// File: rtl/tmatch_entry.sv
// One table entry: stored key, care mask, action, valid and activity
// flags, plus the ternary compare against the search key.
// Assumes the update strobes are mutually exclusive, except for set_hit,
// which may coincide with any of them. The owner guarantees this.
module tmatch_entry #(
    parameter int KEY_W = 32,
    parameter int ACT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_full,
    input  logic             wr_act,
    input  logic             clr_act,
    input  logic             set_hit,
    input  logic [KEY_W-1:0] din_key,
    input  logic [KEY_W-1:0] din_mask,
    input  logic [ACT_W-1:0] din_act,
    input  logic             din_valid,
    input  logic [KEY_W-1:0] srch_key,
    output logic             match,
    output logic [KEY_W-1:0] q_key,
    output logic [KEY_W-1:0] q_mask,
    output logic [ACT_W-1:0] q_act,
    output logic             q_valid,
    output logic             q_active
);

    // Ternary compare: masked-off bits never cause a mismatch
    assign match = q_valid && (((srch_key ^ q_key) & q_mask) == '0);

    // Entry contents: a full write replaces everything, an update only the action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_key   <= '0;
            q_mask  <= '0;
            q_act   <= '0;
            q_valid <= 1'b0;
        end else if (wr_full) begin
            q_key   <= din_key;
            q_mask  <= din_mask;
            q_act   <= din_act;
            q_valid <= din_valid;
        end else if (wr_act) begin
            q_act   <= din_act;
        end
    end

    // Activity flag: a hit or a full write sets it and beats any clear
    always_ff @(posedge clk) begin
        if (!rst_n) q_active <= 1'b0;
        else        q_active <= set_hit | wr_full | (q_active & ~clr_act);
    end

    // R3
    hit_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> q_active);

    // R6
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |=> (q_active && q_valid == $past(din_valid) && q_act == $past(din_act)));

    // R8
    action_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |=> ($stable(q_key) && $stable(q_mask) && $stable(q_valid)));

    // R9
    clear_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_act && !set_hit) |=> !q_active);

    // R10
    hit_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_act && set_hit) |=> q_active);

endmodule

// File: rtl/tmatch_prio.sv
// Lowest-index-first priority picker over the entry match vector.
// Assumes N >= 2 so that the index width is at least one bit.
module tmatch_prio #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     match,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    // Scan from the top down so the lowest matching index is the last one kept
    always_comb begin
        any   = |match;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx      = IDX_W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmatch_table.sv
// Ternary match table top.
// Holds DEPTH entries, runs a registered one-cycle lookup with
// lowest-index priority and handles one management operation per cycle.
// Assumes DEPTH >= 2. A lookup compares against the contents present
// before the clock edge at which it is sampled.
module tmatch_table
    import tmatch_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int KEY_W = 32,
    parameter int ACT_W = 16,
    parameter int OFF_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srch_vld,
    input  logic [KEY_W-1:0] srch_key,
    output logic             res_vld,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic [ACT_W-1:0] res_act,
    input  logic             mgmt_vld,
    input  logic             mgmt_wr,
    input  logic [1:0]       mgmt_op,
    input  logic [OFF_W-1:0] mgmt_off,
    input  logic [KEY_W-1:0] mgmt_key,
    input  logic [KEY_W-1:0] mgmt_mask,
    input  logic [ACT_W-1:0] mgmt_act,
    input  logic             mgmt_valid,
    output logic             rd_vld,
    output logic [KEY_W-1:0] rd_key,
    output logic [KEY_W-1:0] rd_mask,
    output logic [ACT_W-1:0] rd_act,
    output logic             rd_valid,
    output logic             rd_active,
    output logic             mgmt_err
);

    localparam logic [OFF_W:0] DEPTH_LIM = (OFF_W + 1)'(DEPTH);

    logic                        in_range;
    logic                        accept;
    logic [IDX_W-1:0]            sel_idx;
    logic [DEPTH-1:0]            match_v;
    logic [DEPTH-1:0]            grant;
    logic                        any_hit;
    logic [IDX_W-1:0]            win_idx;
    logic [DEPTH-1:0][KEY_W-1:0] e_key;
    logic [DEPTH-1:0][KEY_W-1:0] e_mask;
    logic [DEPTH-1:0][ACT_W-1:0] e_act;
    logic [DEPTH-1:0]            e_valid;
    logic [DEPTH-1:0]            e_active;
    logic [ACT_W-1:0]            win_act;
    logic [KEY_W-1:0]            sel_key;
    logic [KEY_W-1:0]            sel_mask;
    logic [ACT_W-1:0]            sel_act;
    logic                        sel_valid;
    logic                        sel_active;

    // Offset range check and entry select
    assign in_range = {1'b0, mgmt_off} < DEPTH_LIM;
    assign accept   = mgmt_vld && in_range;
    assign sel_idx  = mgmt_off[IDX_W-1:0];

    // Per-entry decode and storage
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic here;
        logic wr_full;
        logic wr_act;
        logic clr_act;

        assign here    = accept && (sel_idx == IDX_W'(g));
        assign wr_full = here && mgmt_wr && (mgmt_op == WR_FULL);
        assign wr_act  = here && mgmt_wr && (mgmt_op == WR_ACTION);
        assign clr_act = here && (mgmt_wr ? (mgmt_op == WR_CLEAR_ACT)
                                          : (mgmt_op == QRY_CLEAR_ACT));

        tmatch_entry #(.KEY_W(KEY_W), .ACT_W(ACT_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_full  (wr_full),
            .wr_act   (wr_act),
            .clr_act  (clr_act),
            .set_hit  (srch_vld && grant[g]),
            .din_key  (mgmt_key),
            .din_mask (mgmt_mask),
            .din_act  (mgmt_act),
            .din_valid(mgmt_valid),
            .srch_key (srch_key),
            .match    (match_v[g]),
            .q_key    (e_key[g]),
            .q_mask   (e_mask[g]),
            .q_act    (e_act[g]),
            .q_valid  (e_valid[g]),
            .q_active (e_active[g])
        );
    end

    tmatch_prio #(.N(DEPTH), .IDX_W(IDX_W)) u_prio (
        .match(match_v),
        .any  (any_hit),
        .idx  (win_idx),
        .grant(grant)
    );

    // AND-OR select of the winning action
    always_comb begin
        win_act = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) win_act = win_act | e_act[i];
        end
    end

    // Management read mux by offset
    always_comb begin
        sel_key    = '0;
        sel_mask   = '0;
        sel_act    = '0;
        sel_valid  = 1'b0;
        sel_active = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                sel_key    = e_key[i];
                sel_mask   = e_mask[i];
                sel_act    = e_act[i];
                sel_valid  = e_valid[i];
                sel_active = e_active[i];
            end
        end
    end

    // Registered lookup result, zeroed on a miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            res_hit <= 1'b0;
            res_idx <= '0;
            res_act <= '0;
        end else begin
            res_vld <= srch_vld;
            res_hit <= srch_vld && any_hit;
            res_idx <= (srch_vld && any_hit) ? win_idx : '0;
            res_act <= (srch_vld && any_hit) ? win_act : '0;
        end
    end

    // Registered query data and range error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld    <= 1'b0;
            rd_key    <= '0;
            rd_mask   <= '0;
            rd_act    <= '0;
            rd_valid  <= 1'b0;
            rd_active <= 1'b0;
            mgmt_err  <= 1'b0;
        end else begin
            rd_vld   <= accept && !mgmt_wr;
            mgmt_err <= mgmt_vld && !in_range;
            if (accept && !mgmt_wr) begin
                rd_key    <= sel_key;
                rd_mask   <= sel_mask;
                rd_act    <= sel_act;
                rd_valid  <= sel_valid;
                rd_active <= sel_active;
            end
        end
    end

    // R2
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any_hit == (grant != '0)));

    // R2
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_vld);

    // R11
    err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_err |-> !rd_vld);

    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_idx == '0 && res_act == '0));

endmodule

// File: tb/tmatch_table_test.sv
`timescale 1ns/1ps
module tmatch_table_test;

    localparam int DEPTH = 16;
    localparam int KW    = 32;
    localparam int AW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          srch_vld = 1'b0;
    logic [KW-1:0] srch_key = '0;
    logic          res_vld, res_hit;
    logic [3:0]    res_idx;
    logic [AW-1:0] res_act;
    logic          mgmt_vld = 1'b0, mgmt_wr = 1'b0, mgmt_valid = 1'b0;
    logic [1:0]    mgmt_op = '0;
    logic [15:0]   mgmt_off = '0;
    logic [KW-1:0] mgmt_key = '0, mgmt_mask = '0;
    logic [AW-1:0] mgmt_act = '0;
    logic          rd_vld, rd_valid, rd_active, mgmt_err;
    logic [KW-1:0] rd_key, rd_mask;
    logic [AW-1:0] rd_act;

    int nchk = 0;
    int nerr = 0;

    logic [KW-1:0] m_key  [DEPTH];
    logic [KW-1:0] m_mask [DEPTH];
    logic [AW-1:0] m_act  [DEPTH];
    logic          m_val  [DEPTH];
    logic          m_actv [DEPTH];

    always #4 clk = ~clk;

    tmatch_table uut (
        .clk(clk), .rst_n(rst_n),
        .srch_vld(srch_vld), .srch_key(srch_key),
        .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx), .res_act(res_act),
        .mgmt_vld(mgmt_vld), .mgmt_wr(mgmt_wr), .mgmt_op(mgmt_op), .mgmt_off(mgmt_off),
        .mgmt_key(mgmt_key), .mgmt_mask(mgmt_mask), .mgmt_act(mgmt_act),
        .mgmt_valid(mgmt_valid),
        .rd_vld(rd_vld), .rd_key(rd_key), .rd_mask(rd_mask), .rd_act(rd_act),
        .rd_valid(rd_valid), .rd_active(rd_active), .mgmt_err(mgmt_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Lowest valid matching index under the model; returns -1 on miss
    function automatic int model_lookup(input logic [KW-1:0] k);
        for (int i = 0; i < DEPTH; i++)
            if (m_val[i] && (((k ^ m_key[i]) & m_mask[i]) == '0)) return i;
        return -1;
    endfunction

    // One cycle: drive both ports at a falling edge, check at the next falling edge
    task automatic step(input string tag,
                        input bit sv, input logic [KW-1:0] sk,
                        input bit mv, input bit mw, input logic [1:0] op,
                        input logic [15:0] off, input logic [KW-1:0] mk,
                        input logic [KW-1:0] mm, input logic [AW-1:0] ma,
                        input bit mvl);
        int win;
        bit inr, e_rdv, e_err;
        int o;
        logic [KW-1:0] e_k, e_m;
        logic [AW-1:0] e_a;
        logic e_v, e_ac;
        srch_vld = sv; srch_key = sk;
        mgmt_vld = mv; mgmt_wr = mw; mgmt_op = op; mgmt_off = off;
        mgmt_key = mk; mgmt_mask = mm; mgmt_act = ma; mgmt_valid = mvl;
        win   = sv ? model_lookup(sk) : -1;
        inr   = (off < 16'(DEPTH));
        e_err = mv && !inr;
        e_rdv = mv && inr && !mw;
        o     = inr ? int'(off) : 0;
        e_k = m_key[o]; e_m = m_mask[o]; e_a = m_act[o]; e_v = m_val[o]; e_ac = m_actv[o];
        if (mv && inr) begin
            if (mw) begin
                case (op)
                    2'd0: begin
                        m_key[o] = mk; m_mask[o] = mm; m_act[o] = ma;
                        m_val[o] = mvl; m_actv[o] = 1'b1;
                    end
                    2'd1: m_act[o] = ma;
                    2'd2: m_actv[o] = 1'b0;
                    default: ;
                endcase
            end else if (op == 2'd1) begin
                m_actv[o] = 1'b0;
            end
        end
        if (win >= 0) m_actv[win] = 1'b1;
        @(negedge clk);
        chk(tag, "res_vld", 64'(res_vld), 64'(sv));
        chk(tag, "res_hit", 64'(res_hit), 64'(win >= 0));
        chk(tag, "res_idx", 64'(res_idx), (win >= 0) ? 64'(win) : 64'd0);
        chk(tag, "res_act", 64'(res_act), (win >= 0) ? 64'(e_a_of(win, o, e_a)) : 64'd0);
        chk(tag, "mgmt_err", 64'(mgmt_err), 64'(e_err));
        chk(tag, "rd_vld", 64'(rd_vld), 64'(e_rdv));
        if (e_rdv) begin
            chk(tag, "rd_key", 64'(rd_key), 64'(e_k));
            chk(tag, "rd_mask", 64'(rd_mask), 64'(e_m));
            chk(tag, "rd_act", 64'(rd_act), 64'(e_a));
            chk(tag, "rd_valid", 64'(rd_valid), 64'(e_v));
            chk(tag, "rd_active", 64'(rd_active), 64'(e_ac));
        end
        srch_vld = 1'b0; mgmt_vld = 1'b0;
    endtask

    // Action of the winner as it was before this cycle's update
    function automatic logic [AW-1:0] e_a_of(input int w, input int o, input logic [AW-1:0] pre_o);
        if (w == o) return pre_o;
        return m_act[w];
    endfunction

    task automatic rd(input string tag, input logic [15:0] off);
        step(tag, 0, '0, 1, 0, 2'd0, off, '0, '0, '0, 0);
    endtask

    task automatic wr(input string tag, input logic [1:0] op, input logic [15:0] off,
                      input logic [KW-1:0] k, input logic [KW-1:0] m,
                      input logic [AW-1:0] a, input bit v);
        step(tag, 0, '0, 1, 1, op, off, k, m, a, v);
    endtask

    task automatic look(input string tag, input logic [KW-1:0] k);
        step(tag, 1, k, 0, 0, 2'd0, '0, '0, '0, '0, 0);
    endtask

    localparam logic [KW-1:0] K = 32'h5A3C_96E0;

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h2468_ACE1);
        for (int i = 0; i < DEPTH; i++) begin
            m_key[i] = '0; m_mask[i] = '0; m_act[i] = '0; m_val[i] = 0; m_actv[i] = 0;
        end
        repeat (4) @(negedge clk);
        // R12: outputs low during and after reset
        chk("R12", "res_vld", 64'(res_vld), 64'd0);
        chk("R12", "rd_vld", 64'(rd_vld), 64'd0);
        chk("R12", "mgmt_err", 64'(mgmt_err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R12", 16'd3);
        look("R12", '0);

        // R6: full write, read back with activity set
        wr("R6", 2'd0, 16'd5, K, 32'hFFFF_FFFF, 16'h1234, 1);
        rd("R6", 16'd5);
        // R2 exact hit, R1 single differing cared bit misses
        look("R2", K);
        look("R1", K ^ 32'h1);
        // R1 masked-off bits ignored; R2 lowest index wins
        wr("R1", 2'd0, 16'd2, K ^ 32'hF0, 32'hFFFF_FF0F, 16'h0222, 1);
        look("R2", K);
        look("R1", K ^ 32'h30);
        // R9 clear activity only, R3 lookup sets it again
        wr("R9", 2'd2, 16'd2, '0, '0, '0, 0);
        rd("R9", 16'd2);
        look("R3", K);
        rd("R3", 16'd2);
        // R5 clear-on-read returns old activity, then R4 plain read shows it cleared
        step("R5", 0, '0, 1, 0, 2'd1, 16'd5, '0, '0, '0, 0);
        rd("R4", 16'd5);
        rd("R4", 16'd5);
        // R9 write code 3 changes nothing
        wr("R9", 2'd3, 16'd5, 32'hFFFF_FFFF, '0, 16'hDEAD, 1);
        rd("R9", 16'd5);
        // R8 action-only update
        wr("R8", 2'd1, 16'd2, 32'h0, 32'h0, 16'hBEEF, 0);
        rd("R8", 16'd2);
        look("R8", K);
        // R7 delete entry 2; lookup falls to entry 5
        wr("R7", 2'd0, 16'd2, K, 32'hFFFF_FFFF, 16'h7777, 0);
        look("R7", K);
        // R10 hit and clear on the same entry in one cycle, both clear styles
        step("R10", 1, K, 1, 1, 2'd2, 16'd5, '0, '0, '0, 0);
        rd("R10", 16'd5);
        step("R10", 1, K, 1, 0, 2'd1, 16'd5, '0, '0, '0, 0);
        rd("R10", 16'd5);
        // R11 out-of-range write and query are ignored and flagged
        wr("R11", 2'd0, 16'd16, 32'h0, 32'h0, 16'h9999, 1);
        wr("R11", 2'd0, 16'h8005, 32'h0, 32'h0, 16'h9999, 1);
        step("R11", 0, '0, 1, 0, 2'd0, 16'hFFFF, '0, '0, '0, 0);
        rd("R11", 16'd0);
        rd("R11", 16'd5);
        look("R11", K);

        // Random mix of lookups and management operations
        for (int n = 0; n < 4000; n++) begin
            bit sv, mv, mw, v;
            logic [1:0] op;
            logic [15:0] off;
            logic [KW-1:0] sk, mk, mm;
            logic [AW-1:0] ma;
            int mk_sel;
            sv  = ($urandom % 3) != 0;
            mv  = ($urandom % 2) != 0;
            mw  = ($urandom % 2) != 0;
            op  = 2'($urandom % 4);
            off = (($urandom % 16) == 0) ? 16'(16 + ($urandom % 200)) : 16'($urandom % 16);
            sk  = K ^ KW'($urandom % 16);
            mk  = K ^ KW'($urandom % 16);
            mk_sel = int'($urandom % 4);
            case (mk_sel)
                0: mm = 32'hFFFF_FFFF;
                1: mm = 32'hFFFF_FFF0;
                2: mm = 32'hFFFF_FFFC;
                default: mm = 32'hFFFF_FFF0 | KW'($urandom % 16);
            endcase
            ma = 16'($urandom);
            v  = ($urandom % 5) != 0;
            step("R2", sv, sk, mv, mw, op, off, mk, mm, ma, v);
        end
        for (int i = 0; i < DEPTH; i++) rd("R4", 16'(i));

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule